// File: doc/BRIEF.md
# Chained Multiply-Add Dot-Product Pipeline

This block computes the matrix product C = A·Bᵀ that results when a convolution is lowered to a matrix multiply. Each row of A is one image patch and each row of B is one filter. Both share an inner dimension of `STAGES*TERMS` terms, which is 25 by default. The reduction is unrolled across a daisy chain of `STAGES` identical stages. Each stage multiplies its own slice of the terms and adds that slice to the partial sum handed to it by the stage before. The last stage therefore produces a finished element of C.

A single two-level loop generator walks the rows of A in the outer loop and the filters in the inner loop. It issues one (row, filter) pair per cycle. The pair travels down the chain next to its partial sum, so the chain holds up to `STAGES` dot products in flight. Once the chain is full, it retires one element of C per cycle. The A and B contents are supplied as preloaded flat vectors. The C contents are held in a result store that drives a flat output. A `done` pulse marks the end of a run.

Top module: `cmac_chain`

## Requirements
- R1: Element C[r][f] equals the sum, over k = 0..`STAGES*TERMS`-1, of A[r][k]·B[f][k]. The operands are signed 16-bit values. A[r][k] is at `a_flat` bit (r·K+k)·16, B[f][k] is at `b_flat` bit (f·K+k)·16, and C[r][f] is at `c_flat` bit (r·FILTERS+f)·32, with K = `STAGES*TERMS`.
- R2: Stage s contributes exactly terms s·TERMS through s·TERMS+TERMS-1, and its result is added to the partial sum it receives. Stage 0 starts from zero.
- R3: Partial sums and results are 32 bits wide with two's-complement wraparound. Each stage holds its token for exactly one cycle before passing it on.
- R4: After a start is accepted, pairs are issued with the row as the outer loop and the filter as the inner loop, one pair per cycle. `done` is high in the cycle that follows clock edge number ROWS·FILTERS+STAGES+1, counting the accepting edge as edge 0.
- R5: `done` is a one-cycle pulse. It comes one cycle after the last element of C has been written, and `busy` is low while `done` is high.
- R6: A `start` that is seen while `busy` is high is ignored. It does not restart the loops, does not change any result and causes no extra `done`.
- R7: After reset, `busy` and `done` are low and every element of `c_flat` is zero.
- R8: Results hold their values after a run ends. A new start after `done` is accepted and overwrites every element of C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| a_flat | input | ROWS·K·16 | Preloaded patch matrix A |
| b_flat | input | FILTERS·K·16 | Preloaded filter matrix B |
| c_flat | output | ROWS·FILTERS·32 | Result matrix C |
| busy | output | 1 | A run is in flight |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
One operand pattern is nonzero in a single term per row, and that term moves from stage to stage as the row changes. A stage that summed the wrong term slice would put every such element of C at zero or at a wrong product. Full-scale operands push the 25-term sum past 32 bits, so a sum that saturated or was widened would miss the wrapped value. The bench counts the edges from start to `done` and fires a second `start` in the middle of a run. An off-by-one drain, or a restart of the loop generator, then shows up as a wrong cycle count or an extra `done` pulse.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 32;
    localparam int IDX_W  = 16;

    typedef struct packed {
        logic                     vld;
        logic                     last;
        logic [IDX_W-1:0]         row;
        logic [IDX_W-1:0]         flt;
        logic signed [ACC_W-1:0]  psum;
    } tok_t;

    function automatic logic signed [ACC_W-1:0] mul_ext(
        input logic signed [DATA_W-1:0] x,
        input logic signed [DATA_W-1:0] y);
        logic signed [ACC_W-1:0] xe;
        logic signed [ACC_W-1:0] ye;
        xe = x;
        ye = y;
        return xe * ye;
    endfunction
endpackage

// File: rtl/cmac_loop_gen.sv
module cmac_loop_gen
    import cmac_pkg::*;
#(
    parameter int OUTER = 4,
    parameter int INNER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             valid,
    output logic             first,
    output logic             last,
    output logic [IDX_W-1:0] outer_idx,
    output logic [IDX_W-1:0] inner_idx
);
    localparam logic [IDX_W-1:0] O_END = IDX_W'(OUTER - 1);
    localparam logic [IDX_W-1:0] I_END = IDX_W'(INNER - 1);

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] o;
        logic [IDX_W-1:0] i;
    } gen_t;

    gen_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.o == O_END) && (st_q.i == I_END);

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (go) begin
                st_d.run = 1'b1;
                st_d.o   = '0;
                st_d.i   = '0;
            end
        end else if (at_end) begin
            st_d.run = 1'b0;
        end else if (st_q.i == I_END) begin
            st_d.i = '0;
            st_d.o = st_q.o + 1'b1;
        end else begin
            st_d.i = st_q.i + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid     = st_q.run;
    assign first     = st_q.run && (st_q.o == '0) && (st_q.i == '0);
    assign last      = st_q.run && at_end;
    assign outer_idx = st_q.o;
    assign inner_idx = st_q.i;
endmodule

// File: rtl/cmac_stage.sv
module cmac_stage
    import cmac_pkg::*;
#(
    parameter int ROWS      = 4,
    parameter int FILTERS   = 3,
    parameter int STAGES    = 5,
    parameter int TERMS     = 5,
    parameter int STAGE_IDX = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ROWS*STAGES*TERMS*DATA_W-1:0]    a_flat,
    input  logic [FILTERS*STAGES*TERMS*DATA_W-1:0] b_flat,
    input  tok_t                            tok_in,
    output tok_t                            tok_out
);
    localparam int K    = STAGES * TERMS;
    localparam int COL0 = STAGE_IDX * TERMS;

    tok_t tok_d, tok_q;
    logic signed [ACC_W-1:0] acc;

    // Accumulator: cleared to the incoming partial sum at the first term,
    // written into the outgoing token after the last term of the slice.
    always_comb begin
        acc = tok_in.psum;
        for (int t = 0; t < TERMS; t++) begin
            acc = acc + mul_ext(
                a_flat[(int'(tok_in.row) * K + COL0 + t) * DATA_W +: DATA_W],
                b_flat[(int'(tok_in.flt) * K + COL0 + t) * DATA_W +: DATA_W]);
        end
        tok_d      = tok_in;
        tok_d.psum = tok_in.vld ? acc : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= '0;
        else        tok_q <= tok_d;
    end

    assign tok_out = tok_q;
endmodule

// File: rtl/cmac_chain.sv
module cmac_chain
    import cmac_pkg::*;
#(
    parameter int ROWS    = 4,
    parameter int FILTERS = 3,
    parameter int STAGES  = 5,
    parameter int TERMS   = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [ROWS*STAGES*TERMS*DATA_W-1:0]    a_flat,
    input  logic [FILTERS*STAGES*TERMS*DATA_W-1:0] b_flat,
    output logic [ROWS*FILTERS*ACC_W-1:0]          c_flat,
    output logic                                   busy,
    output logic                                   done
);
    localparam int NRES = ROWS * FILTERS;

    typedef struct packed {
        logic wr_last;
        logic done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ACC_W-1:0] c_mem_d [NRES];
    logic [ACC_W-1:0] c_mem_q [NRES];

    tok_t              chain [STAGES+1];
    logic [STAGES:0]   vld_vec;
    logic              gen_vld, gen_first, gen_last, accept;
    logic [IDX_W-1:0]  gen_row, gen_flt;
    logic              wr_en, wr_last;
    logic [IDX_W-1:0]  wr_row;

    assign accept = start && !busy;

    cmac_loop_gen #(.OUTER(ROWS), .INNER(FILTERS)) gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept),
        .valid     (gen_vld),
        .first     (gen_first),
        .last      (gen_last),
        .outer_idx (gen_row),
        .inner_idx (gen_flt)
    );

    always_comb begin
        chain[0]      = '0;
        chain[0].vld  = gen_vld;
        chain[0].last = gen_last;
        chain[0].row  = gen_row;
        chain[0].flt  = gen_flt;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cmac_stage #(
            .ROWS(ROWS), .FILTERS(FILTERS), .STAGES(STAGES),
            .TERMS(TERMS), .STAGE_IDX(s)
        ) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_flat  (a_flat),
            .b_flat  (b_flat),
            .tok_in  (chain[s]),
            .tok_out (chain[s+1])
        );
    end

    for (genvar s = 0; s <= STAGES; s++) begin : g_vld
        assign vld_vec[s] = chain[s].vld;
    end

    assign wr_en   = chain[STAGES].vld;
    assign wr_last = chain[STAGES].last;
    assign wr_row  = chain[STAGES].row;

    always_comb begin
        c_mem_d = c_mem_q;
        if (wr_en) begin
            c_mem_d[int'(chain[STAGES].row) * FILTERS + int'(chain[STAGES].flt)]
                = chain[STAGES].psum;
        end
        ctl_d.wr_last = wr_en && wr_last;
        ctl_d.done    = ctl_q.wr_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NRES; i++) c_mem_q[i] <= '0;
        end else begin
            ctl_q   <= ctl_d;
            c_mem_q <= c_mem_d;
        end
    end

    for (genvar i = 0; i < NRES; i++) begin : g_out
        assign c_flat[i*ACC_W +: ACC_W] = c_mem_q[i];
    end

    assign busy = (|vld_vec) || ctl_q.wr_last;
    assign done = ctl_q.done;
endmodule

// File: rtl/cmac_chain_chk.sv
module cmac_chain_chk
    import cmac_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int STAGES = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             gen_first,
    input logic             wr_en,
    input logic             wr_last,
    input logic [IDX_W-1:0] wr_row,
    input logic [STAGES:0]  vld_vec
);
    // R5: done comes one cycle after the write of the final element
    p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en && wr_last, 2));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: loops only begin from an idle start
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gen_first |-> $past(start && !busy));

    p_start_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> gen_first);

    // R4: retired rows stay inside the matrix
    p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row < IDX_W'(ROWS)));

    // R3: each stage hands its token on after exactly one cycle
    for (genvar s = 0; s < STAGES; s++) begin : g_step
        p_chain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_vec[s] |=> vld_vec[s+1]);
    end
endmodule

bind cmac_chain cmac_chain_chk #(.ROWS(ROWS), .STAGES(STAGES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .gen_first (gen_first),
    .wr_en     (wr_en),
    .wr_last   (wr_last),
    .wr_row    (wr_row),
    .vld_vec   (vld_vec)
);

// File: tb/cmac_chain_tb_top.sv
`timescale 1ns/1ps
module cmac_chain_tb_top;
    localparam int ROWS = 4, FILTERS = 3, STAGES = 5, TERMS = 5;
    localparam int K = STAGES * TERMS;
    localparam int NRES = ROWS * FILTERS;
    localparam int LAT = NRES + STAGES + 1;

    typedef struct packed {
        logic [7:0]  mode;
        logic        use_spot;
        logic [31:0] spot;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd0, 1'b1, 32'hFFFF_EBB0},   // ramp: -5200
        '{8'd1, 1'b1, 32'h4000_0000},   // full negative: wraps (R3)
        '{8'd2, 1'b0, 32'h0},           // alternating sign
        '{8'd3, 1'b1, 32'd100},         // one term per row (R2)
        '{8'd4, 1'b1, 32'hC00C_8000}    // max times min: wraps (R3)
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [ROWS*K*16-1:0]    a_flat = '0;
    logic [FILTERS*K*16-1:0] b_flat = '0;
    logic [NRES*32-1:0]      c_flat;
    logic busy, done;
    int total = 0, bad = 0;
    bit hung = 0;

    always #2.5 clk = ~clk;

    cmac_chain #(.ROWS(ROWS), .FILTERS(FILTERS), .STAGES(STAGES), .TERMS(TERMS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .a_flat(a_flat),
        .b_flat(b_flat), .c_flat(c_flat), .busy(busy), .done(done));

    function automatic logic signed [15:0] a_val(int mode, int r, int k);
        case (mode)
            0: return 16'(r * K + k + 1);
            1: return 16'sh8000;
            2: return 16'((k % 2 == 1) ? -(r + k * 37) : (r + k * 37));
            3: return (k == r * 6) ? 16'(100 + r) : 16'sd0;
            default: return 16'sh7FFF;
        endcase
    endfunction

    function automatic logic signed [15:0] b_val(int mode, int f, int k);
        case (mode)
            0: return 16'(f - k);
            1: return 16'sh8000;
            2: return 16'(32767 - f * 1000 - k);
            3: return 16'(k + 1 + f * 50);
            default: return 16'sh8000;
        endcase
    endfunction

    task automatic load(input int mode);
        for (int r = 0; r < ROWS; r++)
            for (int k = 0; k < K; k++) a_flat[(r*K+k)*16 +: 16] = a_val(mode, r, k);
        for (int f = 0; f < FILTERS; f++)
            for (int k = 0; k < K; k++) b_flat[(f*K+k)*16 +: 16] = b_val(mode, f, k);
    endtask

    function automatic logic [31:0] expect_c(int mode, int r, int f);
        logic signed [31:0] acc = 0;
        logic signed [31:0] x, y;
        for (int k = 0; k < K; k++) begin
            x = a_val(mode, r, k);
            y = b_val(mode, f, k);
            acc = acc + x * y;
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // drive start at a negedge, count edges until done is seen
    task automatic run(output int cycles, input int mid_start_at);
        cycles = 0;
        @(negedge clk) start = 1;
        @(posedge clk);
        @(negedge clk) start = 0;
        while (!done && cycles < 1000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            start = (cycles == mid_start_at);
        end
        start = 0;
    endtask

    task automatic check_all(input string req, input int mode);
        for (int r = 0; r < ROWS; r++)
            for (int f = 0; f < FILTERS; f++)
                check(req, c_flat[(r*FILTERS+f)*32 +: 32], expect_c(mode, r, f));
    endtask

    initial begin
        int cyc;
        int extra;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 busy", {31'd0, busy}, 32'd0);
        check("R7 done", {31'd0, done}, 32'd0);
        check("R7 c_flat", {31'd0, |c_flat}, 32'd0);
        rst_n = 1;

        foreach (VECS[i]) begin
            load(int'(VECS[i].mode));
            run(cyc, -1);
            check("R4 latency", cyc, LAT);
            check("R5 busy low at done", {31'd0, busy}, 32'd0);
            check_all("R1 R2 R3 result", int'(VECS[i].mode));
            if (VECS[i].use_spot)
                check("R1 spot C00", c_flat[31:0], VECS[i].spot);
            @(negedge clk);
            check("R5 done one cycle", {31'd0, done}, 32'd0);
        end

        // R8: results hold after the run ends
        repeat (10) @(negedge clk);
        check_all("R8 hold", 4);

        // R6: start during a run is ignored
        load(0);
        run(cyc, 4);
        check("R6 latency with mid start", cyc, LAT);
        check_all("R6 results", 0);
        extra = 0;
        for (int n = 0; n < 2 * LAT; n++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check("R6 no second run", extra, 0);

        // R8: a new run after done overwrites all results
        load(3);
        run(cyc, -1);
        check("R8 rerun latency", cyc, LAT);
        check_all("R8 overwrite", 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        hung = 1;
        total++;
        bad++;
        $display("FAIL watchdog got=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule